// File: doc/BRIEF.md
# DMA Channel Enable and Request-Mask Control Bank

This block holds two per-channel control vectors for a 14-channel DMA controller. One vector enables each channel and the other masks its requests. Software never writes either vector directly. Each vector has a write-one-to-set alias and a write-one-to-clear alias. A zero bit in a write leaves that channel alone, so software can change one channel without a read-modify-write sequence.

The block has a simple synchronous slave port with address, write enable, write data and read data. Read data is combinational from the current address. The block also takes a raw request vector from the peripherals. It gives out a registered qualified request for each channel, along with the live enable and mask vectors for the rest of the controller.

Top module: `dma_chctl_bank`

## Requirements
- R1: The synchronous active-low reset clears the enable vector, the mask vector and the qualified request output to zero.
- R2: A write to offset 0x20 sets the mask bit of every channel C whose write-data bit C is 1. Zero bits leave the mask unchanged. The new value is visible on the cycle after the write edge.
- R3: A read at offset 0x20 returns the mask vector in bits 13:0, with bit C for channel C; 1 means masked and 0 means unmasked.
- R4: A write to offset 0x24 clears the mask bit of every channel C whose write-data bit C is 1. Zero bits have no effect.
- R5: A write to offset 0x28 sets the enable bit of every channel whose data bit is 1. Zero bits have no effect. A read at 0x28 returns the enable vector in bits 13:0.
- R6: A write to offset 0x2C clears the enable bit of every channel whose data bit is 1. Zero bits have no effect.
- R7: Reads at the write-only offsets 0x24 and 0x2C, and at any unmapped offset, return zero. Read-data bits 31:14 are always zero.
- R8: Writes to unmapped offsets change neither vector, and write-data bits 31:14 have no effect.
- R9: The qualified request for channel C equals raw request C AND enable C AND NOT mask C, registered once. It uses the vectors as they stood before any write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| periph_req | input | 14 | Raw peripheral request, one bit per channel |
| chan_req | output | 14 | Registered, qualified request per channel |
| chan_enabled | output | 14 | Current enable vector |
| chan_masked | output | 14 | Current mask vector |

## Verification
The assertions check on every cycle that:
- each set alias leaves its written bits at 1 and each clear alias leaves its written bits at 0;
- an idle or unmapped cycle leaves both vectors stable;
- the reserved and write-only read data stay zero;
- no request passes for a channel that was masked or disabled.

Only the bench's scenarios can show the rest, because each needs a known sequence of values. These are: the exact read value at each offset, that zero bits really leave the other channels untouched, the one-cycle timing of the qualified request against a write on the same edge, and the return to the all-zero state after a reset in mid-run.

// File: rtl/dma_chctl_pkg.sv
package dma_chctl_pkg;
  localparam int unsigned OFS_MASK_SET = 32'h20;
  localparam int unsigned OFS_MASK_CLR = 32'h24;
  localparam int unsigned OFS_EN_SET   = 32'h28;
  localparam int unsigned OFS_EN_CLR   = 32'h2C;

  // Next value of a set/clear vector; a set on the same bit beats a clear.
  function automatic logic [31:0] sc_next(input logic [31:0] cur,
                                          input logic [31:0] set_v,
                                          input logic [31:0] clr_v);
    return (cur & ~(clr_v & ~set_v)) | set_v;
  endfunction

  // Qualification of raw requests by enable and mask.
  function automatic logic [31:0] qualify(input logic [31:0] raw,
                                          input logic [31:0] en,
                                          input logic [31:0] msk);
    return raw & en & ~msk;
  endfunction
endpackage

// File: rtl/sc_vector.sv
module sc_vector #(
  parameter int unsigned N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] q
);
  import dma_chctl_pkg::*;

  logic [31:0] nxt_wide;
  logic        any_touch;

  assign nxt_wide  = sc_next(32'(q), 32'(set_v), 32'(clr_v));
  assign any_touch = (|set_v) || (|clr_v);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt_wide[N-1:0];
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((q & $past(set_v)) == $past(set_v))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_v) |=> ((q & $past(clr_v & ~set_v)) == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_touch |=> $stable(q)); // R8
endmodule

// File: rtl/bus_decode.sv
module bus_decode #(
  parameter int unsigned N      = 14,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      en_q,
  input  logic [N-1:0]      msk_q,
  output logic [N-1:0]      en_set,
  output logic [N-1:0]      en_clr,
  output logic [N-1:0]      msk_set,
  output logic [N-1:0]      msk_clr,
  output logic [DATA_W-1:0] rdata
);
  import dma_chctl_pkg::*;

  localparam int unsigned PAD = DATA_W - N;

  logic hit_mset, hit_mclr, hit_eset, hit_eclr, hit_any, wdata_hi_nz;

  assign hit_mset    = (addr == ADDR_W'(OFS_MASK_SET));
  assign hit_mclr    = (addr == ADDR_W'(OFS_MASK_CLR));
  assign hit_eset    = (addr == ADDR_W'(OFS_EN_SET));
  assign hit_eclr    = (addr == ADDR_W'(OFS_EN_CLR));
  assign hit_any     = hit_mset | hit_mclr | hit_eset | hit_eclr;
  assign wdata_hi_nz = |wdata[DATA_W-1:N];

  assign msk_set = (we && hit_mset) ? wdata[N-1:0] : '0;
  assign msk_clr = (we && hit_mclr) ? wdata[N-1:0] : '0;
  assign en_set  = (we && hit_eset) ? wdata[N-1:0] : '0;
  assign en_clr  = (we && hit_eclr) ? wdata[N-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (hit_mset)      rdata = {{PAD{1'b0}}, msk_q};
    else if (hit_eset) rdata = {{PAD{1'b0}}, en_q};
  end

  AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit_any) |-> ((en_set | en_clr | msk_set | msk_clr) == '0)); // R8
  AST_HI_DATA_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata_hi_nz && wdata[N-1:0] == '0) |-> ((en_set | en_clr | msk_set | msk_clr) == '0)); // R8
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:N] == '0); // R7
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mclr || hit_eclr || !hit_any) |-> (rdata == '0)); // R7
endmodule

// File: rtl/req_gate.sv
module req_gate #(
  parameter int unsigned N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] msk_q,
  output logic [N-1:0] req_q
);
  import dma_chctl_pkg::*;

  logic [31:0] gated;
  assign gated = qualify(32'(raw), 32'(en_q), 32'(msk_q));

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= gated[N-1:0];
  end

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & $past(msk_q)) == '0)); // R9
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(en_q)) == '0)); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(raw)) == '0)); // R9
endmodule

// File: rtl/dma_chctl_bank.sv
module dma_chctl_bank #(
  parameter int unsigned N_CH   = 14,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_CH-1:0]   periph_req,
  output logic [N_CH-1:0]   chan_req,
  output logic [N_CH-1:0]   chan_enabled,
  output logic [N_CH-1:0]   chan_masked
);
  logic [N_CH-1:0] en_set, en_clr, msk_set, msk_clr;

  bus_decode #(.N(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .en_q(chan_enabled), .msk_q(chan_masked),
    .en_set(en_set), .en_clr(en_clr), .msk_set(msk_set), .msk_clr(msk_clr),
    .rdata(bus_rdata)
  );

  sc_vector #(.N(N_CH)) u_en (
    .clk(clk), .rst_n(rst_n), .set_v(en_set), .clr_v(en_clr), .q(chan_enabled)
  );

  sc_vector #(.N(N_CH)) u_msk (
    .clk(clk), .rst_n(rst_n), .set_v(msk_set), .clr_v(msk_clr), .q(chan_masked)
  );

  req_gate #(.N(N_CH)) u_req (
    .clk(clk), .rst_n(rst_n), .raw(periph_req), .en_q(chan_enabled),
    .msk_q(chan_masked), .req_q(chan_req)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $fell(rst_n) |=> (chan_enabled == '0 && chan_masked == '0 && chan_req == '0)); // R1
endmodule

// File: tb/sim_dma_chctl_bank.sv
module sim_dma_chctl_bank;
  localparam int PERIOD = 10;
  localparam int NC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [13:0] periph_req = '0;
  logic [13:0] chan_req, chan_enabled, chan_masked;

  int n_checks = 0;
  int n_fail = 0;

  // behavioural reference state
  bit m_en[NC];
  bit m_msk[NC];
  bit m_req[NC];

  always #(PERIOD/2) clk = ~clk;

  dma_chctl_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_req(periph_req),
    .chan_req(chan_req), .chan_enabled(chan_enabled), .chan_masked(chan_masked)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_en[c] = 0; m_msk[c] = 0; m_req[c] = 0;
      end
    end else begin
      for (int c = 0; c < NC; c++)
        m_req[c] = periph_req[c] && m_en[c] && !m_msk[c];
      if (bus_we) begin
        for (int c = 0; c < NC; c++) begin
          if (bus_wdata[c]) begin
            case (bus_addr)
              8'h20: m_msk[c] = 1;
              8'h24: m_msk[c] = 0;
              8'h28: m_en[c] = 1;
              8'h2C: m_en[c] = 0;
              default: ;
            endcase
          end
        end
      end
    end
  end

  function automatic logic [31:0] pack(input bit v[NC]);
    logic [31:0] r = '0;
    for (int c = 0; c < NC; c++) r[c] = v[c];
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h20) return pack(m_msk);
    if (a == 8'h28) return pack(m_en);
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R4 mask vector", 32'(chan_masked), pack(m_msk));
    chk("R5 R6 enable vector", 32'(chan_enabled), pack(m_en));
    chk("R9 qualified request", 32'(chan_req), pack(m_req));
    chk("R3 R5 R7 read data", bus_rdata, model_read(bus_addr));
  endtask

  // one cycle: drive, let the edge pass, compare at the falling edge
  task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d,
                     input logic [13:0] rq);
    bus_addr = a; bus_we = w; bus_wdata = d; periph_req = rq;
    @(negedge clk);
    compare_all();
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(a, 1'b0, 32'h0, periph_req);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: writes during reset are ignored, everything zero
    rst_n = 1'b0;
    cyc(8'h28, 1'b1, 32'h3FFF, 14'h3FFF);
    cyc(8'h20, 1'b1, 32'h3FFF, 14'h3FFF);
    chk("R1 enable after reset", 32'(chan_enabled), 32'h0);
    chk("R1 mask after reset", 32'(chan_masked), 32'h0);
    chk("R1 request after reset", 32'(chan_req), 32'h0);
    rst_n = 1'b1;

    // R5: enable set, read back
    cyc(8'h28, 1'b1, 32'h0000_00F3, 14'h0);
    rd(8'h28);
    chk("R5 enable readback", bus_rdata, 32'h0000_00F3);
    cyc(8'h28, 1'b1, 32'h0, 14'h0);
    chk("R5 zero write keeps enable", 32'(chan_enabled), 32'h00F3);

    // R2/R3: mask set, zero write no effect
    cyc(8'h20, 1'b1, 32'h0000_0005, 14'h0);
    cyc(8'h20, 1'b1, 32'h0, 14'h0);
    chk("R3 mask readback", bus_rdata, 32'h0000_0005);
    chk("R2 zero write keeps mask", 32'(chan_masked), 32'h0005);

    // R4: mask clear, write-only read
    cyc(8'h24, 1'b1, 32'h0000_0001, 14'h0);
    chk("R4 mask after clear", 32'(chan_masked), 32'h0004);
    chk("R7 mask-clear reads zero", bus_rdata, 32'h0);

    // R6: enable clear
    cyc(8'h2C, 1'b1, 32'h0000_00F0, 14'h0);
    chk("R6 enable after clear", 32'(chan_enabled), 32'h0003);
    chk("R7 enable-clear reads zero", bus_rdata, 32'h0);

    // R7/R8: unmapped offsets and high data bits
    cyc(8'h21, 1'b1, 32'hFFFF_FFFF, 14'h0);
    cyc(8'h30, 1'b1, 32'hFFFF_FFFF, 14'h0);
    cyc(8'h1C, 1'b1, 32'hFFFF_FFFF, 14'h0);
    chk("R8 unmapped write ignored en", 32'(chan_enabled), 32'h0003);
    chk("R8 unmapped write ignored mask", 32'(chan_masked), 32'h0004);
    chk("R7 unmapped read zero", bus_rdata, 32'h0);
    cyc(8'h28, 1'b1, 32'hFFFF_C000, 14'h0);
    chk("R8 high data bits inert", 32'(chan_enabled), 32'h0003);
    cyc(8'h28, 1'b1, 32'hFFFF_FFFF, 14'h0);
    chk("R7 reserved read bits zero", bus_rdata, 32'h0000_3FFF);

    // R9: qualification and same-edge write timing
    // en=3FFF mask=0004
    cyc(8'h00, 1'b0, 32'h0, 14'h000F);
    chk("R9 masked channel blocked", 32'(chan_req), 32'h000B);
    cyc(8'h20, 1'b1, 32'h0000_0001, 14'h0003);
    chk("R9 uses pre-write mask", 32'(chan_req), 32'h0003);
    cyc(8'h00, 1'b0, 32'h0, 14'h0003);
    chk("R9 newly masked blocked", 32'(chan_req), 32'h0002);
    cyc(8'h2C, 1'b1, 32'h0000_0002, 14'h0002);
    chk("R9 uses pre-write enable", 32'(chan_req), 32'h0002);
    cyc(8'h00, 1'b0, 32'h0, 14'h0002);
    chk("R9 disabled channel blocked", 32'(chan_req), 32'h0000);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = 8'h20; 1: a = 8'h24; 2: a = 8'h28; 3: a = 8'h2C;
        4: a = 8'h30; default: a = 8'h04;
      endcase
      cyc(a, 1'($urandom_range(0, 1)), $urandom(), 14'($urandom()));
    end

    // R1: mid-run reset
    cyc(8'h28, 1'b1, 32'h3FFF, 14'h3FFF);
    rst_n = 1'b0;
    cyc(8'h20, 1'b1, 32'h3FFF, 14'h3FFF);
    chk("R1 mid-run reset enable", 32'(chan_enabled), 32'h0);
    chk("R1 mid-run reset request", 32'(chan_req), 32'h0);
    rst_n = 1'b1;
    rd(8'h20);
    chk("R1 mask zero after reset", bus_rdata, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule